// File: doc/BRIEF.md
# Triggered Ring Capture Buffer Manager

This block turns a continuous stream of 16-bit samples into addressed 64-bit write beats for a pool of equal-sized memory buffers. Four samples make one beat, and each beat gets the address of the next slot in the current buffer. While no trigger is present, the slot offset wraps inside the current buffer, so the buffer always holds the most recent history.

When a trigger arrives, capture runs on for half a buffer. The buffer is then closed, which puts the trigger point in the middle of the captured data. The next beat goes to the start of the following buffer in the pool, and the input stream does not stall. Each closed buffer is reported through a small completion queue. An entry gives the buffer index and the slot that the write pointer would have used next, so software can put the samples back in time order.

Software hands drained buffers back by writing their index. If the following buffer is still in use when a close happens, the block raises an overflow indication and holds the stream until that buffer is released. It never overwrites the buffer and never drops samples.

Top module: `trig_ring_capture`

## Requirements
- R1: Four accepted samples form one 64-bit beat, with the first sample in bits 15:0 and later samples in ascending 16-bit lanes. The beat is written to address BASE_ADDR + buffer_index*BUF_BYTES + slot*8.
- R2: While no trigger is pending, the slot after the last slot of a buffer is slot 0 of the same buffer.
- R3: After a trigger is sampled in FILL mode, the current buffer takes exactly BUF_BYTES/16 more beats (half a buffer). Only beats formed in cycles after the trigger cycle are counted. The last of these beats closes the buffer.
- R4: The beat after a closing beat goes to slot 0 of buffer index+1, wrapping from NUM_BUFS-1 to 0. No sample is lost or repeated across the switch.
- R5: Each close pushes {buffer index, (closing slot+1) mod slots} into the completion queue. irq is high while the queue holds an entry, cmp_idx and cmp_ofs show the oldest entry, and cmp_pop removes it.
- R6: A trigger that arrives during the post-trigger countdown has no effect on when the buffer closes.
- R7: After reset, buffer 0 is in use and every other buffer is free. A free_valid pulse marks buffer free_idx free, but the request is ignored when free_idx is the buffer currently being filled.
- R8: If the next buffer is in use at a close, ovf is high and the fourth sample of the next beat is refused (smp_ready low) until that buffer is freed. Capture then resumes with no sample lost.
- R9: A beat held with beat_valid high and beat_ready low keeps its address and data. The fourth sample of a beat is refused while the output slot cannot take a new beat.
- R10: After reset, beat_valid, irq and ovf are low and smp_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Sample accepted when high together with smp_valid |
| smp_data | input | 16 | Sample value |
| trig | input | 1 | Capture trigger, sampled each cycle |
| beat_valid | output | 1 | Write beat present |
| beat_ready | input | 1 | Downstream takes the beat |
| beat_addr | output | ADDR_W | Byte address of the beat |
| beat_data | output | 64 | Four packed samples |
| free_valid | input | 1 | Release request for a buffer |
| free_idx | input | IDX_W | Index of the buffer being released |
| irq | output | 1 | Completion queue not empty |
| cmp_idx | output | IDX_W | Index of the oldest closed buffer |
| cmp_ofs | output | OFS_W | Slot where the oldest data of that buffer begins |
| cmp_pop | input | 1 | Removes the oldest completion entry |
| ovf | output | 1 | Waiting for the next buffer to be released |

## Verification
A beat appears on the output one clock edge after its fourth sample is accepted. A completion entry appears (irq rises) on the same edge as the closing beat. A release takes effect one edge after free_valid is sampled, and ovf drops in that same cycle. The bench drives inputs just after the rising edge and reads everything at the falling edge. It logs a beat only when valid and ready are both seen, it checks completions only once the matching closing beat has been logged, and it checks the overflow stall only after it has waited for ovf to rise.

// File: rtl/trc_pkg.sv
package trc_pkg;
   localparam int SMP_W      = 16;
   localparam int LANES      = 4;
   localparam int BEAT_W     = SMP_W * LANES;
   localparam int BEAT_BYTES = BEAT_W / 8;
   localparam int BEAT_SH    = $clog2(BEAT_BYTES);

   typedef enum logic [1:0] {
      CAP_FILL = 2'd0,
      CAP_POST = 2'd1,
      CAP_SWAP = 2'd2
   } cap_state_e;
endpackage

// File: rtl/trc_packer.sv
module trc_packer
   import trc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_fire,
   input  logic [SMP_W-1:0]  in_data,
   output logic              last_lane,
   output logic [BEAT_W-1:0] word
);
   localparam int LANE_W = $clog2(LANES);

   logic [LANE_W-1:0] lane_q;

   assign last_lane = (lane_q == LANE_W'(LANES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (in_fire) lane_q <= lane_q + 1'b1;
   end

   // lanes below the top are held in registers; the top lane is the live sample
   for (genvar k = 0; k < LANES - 1; k++) begin : g_lane
      logic [SMP_W-1:0] acc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  acc_q <= '0;
         else if (in_fire && lane_q == LANE_W'(k))    acc_q <= in_data;
      end
      assign word[k*SMP_W +: SMP_W] = acc_q;
   end
   assign word[BEAT_W-1 -: SMP_W] = in_data;
endmodule

// File: rtl/trc_pool.sv
module trc_pool #(
   parameter int NUM_BUFS = 4,
   parameter int IDX_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rel_valid,
   input  logic [IDX_W-1:0] rel_idx,
   input  logic [IDX_W-1:0] cur_idx,
   input  logic             take,
   input  logic [IDX_W-1:0] take_idx,
   output logic             take_ok
);
   logic [NUM_BUFS-1:0] free_vec;

   for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
      logic free_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            free_q <= (b != 0);
         else if (take && take_idx == IDX_W'(b))
            free_q <= 1'b0;
         else if (rel_valid && rel_idx == IDX_W'(b) && cur_idx != IDX_W'(b))
            free_q <= 1'b1;
      end
      assign free_vec[b] = free_q;
   end

   assign take_ok = free_vec[take_idx];
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem_q[rd_q];

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop)  rd_q <= rd_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/trig_ring_capture.sv
module trig_ring_capture
   import trc_pkg::*;
#(
   parameter int              ADDR_W    = 32,
   parameter int              BUF_BYTES = 1 << 20,
   parameter int              NUM_BUFS  = 100,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
   parameter int              CMP_DEPTH = 8,
   localparam int             BEATS     = BUF_BYTES / BEAT_BYTES,
   localparam int             OFS_W     = $clog2(BEATS),
   localparam int             IDX_W     = $clog2(NUM_BUFS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   output logic              smp_ready,
   input  logic [SMP_W-1:0]  smp_data,
   input  logic              trig,
   output logic              beat_valid,
   input  logic              beat_ready,
   output logic [ADDR_W-1:0] beat_addr,
   output logic [BEAT_W-1:0] beat_data,
   input  logic              free_valid,
   input  logic [IDX_W-1:0]  free_idx,
   output logic              irq,
   output logic [IDX_W-1:0]  cmp_idx,
   output logic [OFS_W-1:0]  cmp_ofs,
   input  logic              cmp_pop,
   output logic              ovf
);
   localparam int HALF   = BEATS / 2;
   localparam int CNT_W  = $clog2(HALF + 1);
   localparam int BUF_SH = $clog2(BUF_BYTES);
   localparam int CMP_W  = IDX_W + OFS_W;

   if (BUF_BYTES < 2 * BEAT_BYTES || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two of at least two beats");
   end
   if (NUM_BUFS < 2) begin : g_bad_pool
      $error("NUM_BUFS must be at least 2");
   end
   if (CMP_DEPTH < 2 || (CMP_DEPTH & (CMP_DEPTH - 1)) != 0) begin : g_bad_cmp
      $error("CMP_DEPTH must be a power of two of at least 2");
   end
   if (IDX_W + BUF_SH > ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the pool");
   end

   cap_state_e        state_q;
   logic [IDX_W-1:0]  cur_q, nxt_idx;
   logic [OFS_W-1:0]  ofs_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              last_lane, nxt_free, closing, accept_last;
   logic              smp_fire, beat_fire, swap_go, cf_full, cf_empty;
   logic [BEAT_W-1:0] word;
   logic [CMP_W-1:0]  cf_dout;

   assign nxt_idx     = (cur_q == IDX_W'(NUM_BUFS - 1)) ? '0 : cur_q + 1'b1;
   assign closing     = (state_q == CAP_POST) && (cnt_q == CNT_W'(1));
   assign accept_last = (state_q != CAP_SWAP) && (!beat_valid || beat_ready) &&
                        !(closing && cf_full);
   assign smp_ready   = !last_lane || accept_last;
   assign smp_fire    = smp_valid && smp_ready;
   assign beat_fire   = smp_fire && last_lane;
   assign swap_go     = (state_q == CAP_SWAP) && nxt_free;
   assign ovf         = (state_q == CAP_SWAP) && !nxt_free;

   trc_packer u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_fire   (smp_fire),
      .in_data   (smp_data),
      .last_lane (last_lane),
      .word      (word)
   );

   trc_pool #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .rel_valid (free_valid),
      .rel_idx   (free_idx),
      .cur_idx   (cur_q),
      .take      (swap_go),
      .take_idx  (nxt_idx),
      .take_ok   (nxt_free)
   );

   trc_fifo #(.W(CMP_W), .DEPTH(CMP_DEPTH)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (beat_fire && closing),
      .din   ({cur_q, ofs_q + 1'b1}),
      .pop   (cmp_pop),
      .dout  (cf_dout),
      .empty (cf_empty),
      .full  (cf_full)
   );

   assign irq     = !cf_empty;
   assign cmp_idx = cf_dout[CMP_W-1 -: IDX_W];
   assign cmp_ofs = cf_dout[OFS_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CAP_FILL;
         cur_q   <= '0;
         ofs_q   <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            CAP_FILL: if (trig) begin
               state_q <= CAP_POST;
               cnt_q   <= CNT_W'(HALF);
            end
            CAP_POST: if (beat_fire) begin
               if (closing) state_q <= CAP_SWAP;
               cnt_q <= cnt_q - 1'b1;
            end
            CAP_SWAP: if (nxt_free) begin
               state_q <= CAP_FILL;
               cur_q   <= nxt_idx;
            end
            default: state_q <= CAP_FILL;
         endcase
         if (swap_go)        ofs_q <= '0;
         else if (beat_fire) ofs_q <= ofs_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_valid <= 1'b0;
         beat_addr  <= '0;
         beat_data  <= '0;
      end else if (beat_fire) begin
         beat_valid <= 1'b1;
         beat_addr  <= BASE_ADDR + (ADDR_W'(cur_q) << BUF_SH) + (ADDR_W'(ofs_q) << BEAT_SH);
         beat_data  <= word;
      end else if (beat_ready) begin
         beat_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/trc_checker.sv
module trc_checker
   import trc_pkg::*;
#(
   parameter int              ADDR_W    = 32,
   parameter int              BUF_BYTES = 64,
   parameter int              NUM_BUFS  = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
   parameter int              IDX_W     = 2,
   parameter int              CNT_W     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              beat_valid,
   input logic              beat_ready,
   input logic [ADDR_W-1:0] beat_addr,
   input logic [BEAT_W-1:0] beat_data,
   input logic              irq,
   input logic [IDX_W-1:0]  cmp_idx,
   input logic              ovf,
   input cap_state_e        state,
   input logic [CNT_W-1:0]  cnt,
   input logic              beat_fire
);
   localparam logic [ADDR_W:0] POOL = (ADDR_W+1)'(NUM_BUFS) * (ADDR_W+1)'(BUF_BYTES);

   a_r1_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> beat_addr[BEAT_SH-1:0] == '0);

   a_r1_in_pool: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> (beat_addr >= BASE_ADDR &&
                      ({1'b0, beat_addr} - {1'b0, BASE_ADDR}) < POOL));

   a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_data)));

   a_r8_no_beat_in_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> !beat_fire);

   a_r8_out_drains: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (!beat_valid || $past(beat_valid && !beat_ready)));

   a_r6_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAP_POST && !beat_fire) |=> (state == CAP_POST && $stable(cnt)));

   a_r3_close: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAP_POST && beat_fire && cnt == CNT_W'(1)) |=> state == CAP_SWAP);

   a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cmp_idx < IDX_W'(NUM_BUFS));
endmodule

bind trig_ring_capture trc_checker #(
   .ADDR_W    (ADDR_W),
   .BUF_BYTES (BUF_BYTES),
   .NUM_BUFS  (NUM_BUFS),
   .BASE_ADDR (BASE_ADDR),
   .IDX_W     (IDX_W),
   .CNT_W     (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .beat_valid (beat_valid),
   .beat_ready (beat_ready),
   .beat_addr  (beat_addr),
   .beat_data  (beat_data),
   .irq        (irq),
   .cmp_idx    (cmp_idx),
   .ovf        (ovf),
   .state      (state_q),
   .cnt        (cnt_q),
   .beat_fire  (beat_fire)
);

// File: tb/trig_ring_capture_test.sv
module trig_ring_capture_test;
   localparam int          CLK_PERIOD = 10;
   localparam int          BUF_BYTES  = 64;
   localparam int          NUM_BUFS   = 3;
   localparam int          SLOTS      = BUF_BYTES / 8;
   localparam int          HALF       = SLOTS / 2;
   localparam logic [31:0] BASE       = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0, trig = 1'b0, beat_ready = 1'b1;
   logic        free_valid = 1'b0, cmp_pop = 1'b0;
   logic [15:0] smp_data = '0;
   logic [1:0]  free_idx = '0;
   logic        smp_ready, beat_valid, irq, ovf;
   logic [31:0] beat_addr;
   logic [63:0] beat_data;
   logic [1:0]  cmp_idx;
   logic [2:0]  cmp_ofs;

   int checks = 0, errors = 0;
   int gsn = 0, nbeats = 0, nexp = 0, ngot = 0;
   int mbuf = 0, mofs = 0, close_at = -1;
   int exp_idx [16];
   int exp_ofs [16];
   string tag = "R2";
   bit done = 1'b0;

   trig_ring_capture #(
      .ADDR_W(32), .BUF_BYTES(BUF_BYTES), .NUM_BUFS(NUM_BUFS),
      .BASE_ADDR(BASE), .CMP_DEPTH(4)
   ) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
      .smp_data(smp_data), .trig(trig), .beat_valid(beat_valid), .beat_ready(beat_ready),
      .beat_addr(beat_addr), .beat_data(beat_data), .free_valid(free_valid),
      .free_idx(free_idx), .irq(irq), .cmp_idx(cmp_idx), .cmp_ofs(cmp_ofs),
      .cmp_pop(cmp_pop), .ovf(ovf)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // beat and completion monitor, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (beat_valid && beat_ready) begin
            logic [63:0] ed;
            logic [31:0] ea;
            for (int k = 0; k < 4; k++) ed[k*16 +: 16] = 16'(4*nbeats + k);
            ea = BASE + 32'(mbuf * BUF_BYTES) + 32'(mofs * 8);
            chk(beat_addr == ea, {tag, " R1 R4 addr"}, 64'(beat_addr), 64'(ea));
            chk(beat_data == ed, {tag, " R1 R4 data"}, beat_data, ed);
            if (nbeats == close_at) begin
               exp_idx[nexp] = mbuf;
               exp_ofs[nexp] = (mofs + 1) % SLOTS;
               nexp++;
               mbuf = (mbuf + 1) % NUM_BUFS;
               mofs = 0;
            end else begin
               mofs = (mofs + 1) % SLOTS;
            end
            nbeats++;
         end
         if (irq && ngot < nexp) begin
            chk(cmp_idx == 2'(exp_idx[ngot]), "R5 cmp_idx", 64'(cmp_idx), 64'(exp_idx[ngot]));
            chk(cmp_ofs == 3'(exp_ofs[ngot]), "R5 cmp_ofs", 64'(cmp_ofs), 64'(exp_ofs[ngot]));
            ngot++;
            cmp_pop = 1'b1;
         end else begin
            cmp_pop = 1'b0;
         end
      end
   end

   task automatic send(input int n, input int t1, input int t2);
      for (int i = 0; i < n; i++) begin
         bit acc;
         smp_valid = 1'b1;
         smp_data  = 16'(gsn);
         trig      = (gsn == t1) || (gsn == t2);
         if (gsn == t1) close_at = gsn / 4 + HALF - 1;
         do begin
            @(negedge clk);
            acc = smp_ready;
            @(posedge clk);
            #1;
            trig = 1'b0;
         end while (!acc);
         gsn++;
      end
      smp_valid = 1'b0;
   endtask

   task automatic release_buf(input logic [1:0] idx);
      @(posedge clk); #1;
      free_valid = 1'b1;
      free_idx   = idx;
      @(posedge clk); #1;
      free_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(beat_valid == 1'b0, "R10 beat_valid", 64'(beat_valid), 0);
      chk(irq == 1'b0, "R10 irq", 64'(irq), 0);
      chk(ovf == 1'b0, "R10 ovf", 64'(ovf), 0);
      chk(smp_ready == 1'b1, "R10 smp_ready", 64'(smp_ready), 1);
      @(posedge clk); #1;

      // R2: free-running wrap inside buffer 0 (beats 0..9)
      tag = "R2";
      send(40, -1, -1);
      // R7: releasing the buffer being filled must be ignored
      release_buf(2'd0);

      // R3 R6: trigger, then a second trigger inside the countdown
      tag = "R3 R6";
      send(40, 41, 45);

      // R9: output backpressure while a close happens
      tag = "R9";
      fork
         send(24, 81, -1);
         begin
            for (int k = 0; k < 40; k++) begin
               @(posedge clk); #1;
               beat_ready = (k % 3) != 0;
            end
            beat_ready = 1'b1;
         end
      join

      // R8: close into a buffer that is still in use
      tag = "R8";
      fork
         send(40, 105, -1);
         begin
            wait (ovf === 1'b1);
            repeat (8) @(negedge clk);
            chk(ovf == 1'b1, "R8 ovf held", 64'(ovf), 1);
            chk(ovf == 1'b1, "R7 buffer 0 still busy", 64'(ovf), 1);
            chk(smp_ready == 1'b0, "R8 stream held", 64'(smp_ready), 0);
            chk(nbeats == 30, "R8 beats before stall", 64'(nbeats), 30);
            release_buf(2'd0);
            @(negedge clk);
            chk(ovf == 1'b0, "R8 ovf cleared", 64'(ovf), 0);
         end
      join

      repeat (10) @(negedge clk);
      chk(nbeats == 36, "R4 total beats", 64'(nbeats), 36);
      chk(nexp == 3, "R3 closes", 64'(nexp), 3);
      chk(ngot == 3, "R5 completions seen", 64'(ngot), 3);
      chk(irq == 1'b0, "R5 queue drained", 64'(irq), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule